// File: doc/BRIEF.md
# Switch-Configured Memory Map Decoder

This block decodes the 16-bit memory address of an 8-bit Z80-style bus for a 32K RAM expansion card. Four configuration switches and a cartridge-present input pick which address windows the card answers. Each claimed window is folded onto a 15-bit physical RAM address. Several windows share the same physical storage, so one 8K slice and one 1K slice each appear at more than one bus address. The block also produces the memory and refresh strobes for the rear expansion connector. Any access the card has claimed is hidden from devices further back on the bus.

The switches and the cartridge-detect signal are sampled into a configuration register on every clock, so a change takes effect one clock later. The address decode, the chip selects and the rear-bus strobes are combinational from the bus signals and that register. Read and write enables for the RAM array come out alongside the RAM select. The RAM array, the cartridge ROM and any video logic sit outside this block.

Top module: `xram_map_dec`

## Requirements
- R1: While reset (`rst_n` low) is applied at a clock edge, the configuration register clears to all switches off and no cartridge. After that edge no RAM or ROM select is raised, and `rear_mreq_n` follows `mreq_n`.
- R2: With `sw_main16k` set, bus addresses 0x4000-0x7FFF select RAM at physical address (addr - 0x4000), i.e. physical 0x0000-0x3FFF.
- R3: With `sw_mirror8k` set and no cartridge, bus addresses 0x2000-0x3FFF and 0xA000-0xBFFF both select RAM at physical 0x6000 + (addr mod 0x2000).
- R4: With `sw_upper16k` set, bus addresses 0xC000-0xFFFF select RAM at physical 0x4000 + (addr - 0xC000). As a result, 0xE000-0xFFFF reaches the same physical 0x6000-0x7FFF slice as R3.
- R5: With `sw_charbd` set, bus addresses 0x8400-0x87FF and 0xC400-0xC7FF both select RAM at physical 0x4400 + (addr mod 0x400). This holds whether or not `sw_upper16k` is set.
- R6: With `cart_present` set, every memory access to 0x0000-0x3FFF raises `rom_sel`. A cartridge disables the R3 windows at both 0x2000 and 0xA000. `rom_sel` and `ram_sel` are never high together.
- R7: `ram_sel` and `rom_sel` rise only while `mreq_n` is low together with `rd_n` or `wr_n` low. `ram_oe` is `ram_sel` gated by a low `rd_n`, and `ram_we` is `ram_sel` gated by a low `wr_n`.
- R8: While `rfsh_n` is low, `ram_we` stays low, even if `wr_n` is low.
- R9: `rear_mreq_n` is high whenever the address falls in an enabled RAM window, or in 0x0000-0x3FFF with a cartridge present. Otherwise it equals `mreq_n`.
- R10: `rear_rfsh_n` is high whenever a cartridge is present and the address lies in 0x0000-0x3FFF. Otherwise it equals `rfsh_n`.
- R11: A change on a switch or on `cart_present` affects the decode only after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration register |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 16 | Bus memory address |
| mreq_n | input | 1 | Bus memory request, active low |
| rfsh_n | input | 1 | Bus refresh indicator, active low |
| rd_n | input | 1 | Bus read strobe, active low |
| wr_n | input | 1 | Bus write strobe, active low |
| sw_main16k | input | 1 | Enables the 16K window at 0x4000 |
| sw_mirror8k | input | 1 | Enables the 8K windows at 0x2000 and 0xA000 |
| sw_charbd | input | 1 | Enables the 1K windows at 0x8400 and 0xC400 |
| sw_upper16k | input | 1 | Enables the 16K window at 0xC000 |
| cart_present | input | 1 | A ROM cartridge is plugged in |
| ram_sel | output | 1 | RAM chip select, active high |
| ram_oe | output | 1 | RAM read enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 15 | Physical RAM address, valid while ram_sel is high |
| rom_sel | output | 1 | Cartridge ROM select |
| rear_mreq_n | output | 1 | Gated memory request to the rear connector |
| rear_rfsh_n | output | 1 | Gated refresh to the rear connector |

## Verification
The bench builds the decoder at its default widths: a 16-bit bus address and a 15-bit physical address. At these widths all 32 combinations of the four switches and the cartridge input can be swept. For each combination, 256 addresses cover every 256-byte page of the map, each with a different low byte. Each address is driven with five bus cycle kinds: idle, read, write, refresh, and refresh with a stray write strobe. This reaches every window edge, both alias pairs, the cartridge override of the mirrored 8K and the overlap of the 1K window inside the upper 16K. Separate directed steps check the reset state and the one-clock delay of a switch change.

// File: rtl/xram_map_pkg.sv
// Package: shared configuration type and the window table of the decoder.
// Assumes a 16-bit bus map; each window is a naturally aligned power-of-two
// block whose base and physical target are fixed by the card layout.
package xram_map_pkg;

    localparam int NWIN      = 6;
    localparam int CART_SPAN = 14;  // cartridge space is the lowest 16K

    typedef struct packed {
        logic main16k;
        logic mirror8k;
        logic charbd;
        logic upper16k;
        logic cart;
    } map_cfg_t;

    typedef enum int {
        WIN_LOW8K   = 0,
        WIN_MAIN16K = 1,
        WIN_CHR_MID = 2,
        WIN_MID8K   = 3,
        WIN_UP16K   = 4,
        WIN_CHR_UP  = 5
    } win_id_t;

    // Bus base address of window i.
    function automatic logic [31:0] win_base(int i);
        case (i)
            WIN_LOW8K:   return 32'h2000;
            WIN_MAIN16K: return 32'h4000;
            WIN_CHR_MID: return 32'h8400;
            WIN_MID8K:   return 32'hA000;
            WIN_UP16K:   return 32'hC000;
            default:     return 32'hC400;
        endcase
    endfunction

    // log2 of the size of window i.
    function automatic int win_span(int i);
        case (i)
            WIN_LOW8K, WIN_MID8K:   return 13;
            WIN_MAIN16K, WIN_UP16K: return 14;
            default:                return 10;
        endcase
    endfunction

    // Physical base of window i.
    function automatic logic [31:0] win_phys(int i);
        case (i)
            WIN_LOW8K, WIN_MID8K: return 32'h6000;
            WIN_MAIN16K:          return 32'h0000;
            WIN_UP16K:            return 32'h4000;
            default:              return 32'h4400;
        endcase
    endfunction

    // Whether window i answers under configuration c.
    function automatic logic win_enabled(int i, map_cfg_t c);
        case (i)
            WIN_LOW8K, WIN_MID8K:     return c.mirror8k & ~c.cart;
            WIN_MAIN16K:              return c.main16k;
            WIN_UP16K:                return c.upper16k;
            default:                  return c.charbd;
        endcase
    endfunction

endpackage

// File: rtl/xram_cfg_reg.sv
// Configuration register: samples switches and cartridge detect each clock.
// Assumes the inputs are already synchronous to clk; clears to all-off on a
// synchronous active-low reset.
module xram_cfg_reg
    import xram_map_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  map_cfg_t cfg_d,
    output map_cfg_t cfg_q
);

    // Capture the configuration, or clear it under reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

endmodule

// File: rtl/xram_win_dec.sv
// Window decoder: compares the address against every window of the table and
// folds hits onto the physical RAM address. Overlapping windows must agree on
// the physical address they produce, since the hits are OR-combined.
module xram_win_dec
    import xram_map_pkg::*;
#(
    parameter int AW = 16,
    parameter int PW = 15
) (
    input  logic [AW-1:0] addr,
    input  map_cfg_t      cfg,
    output logic          hit,
    output logic [PW-1:0] phys,
    output logic          cart_zone
);

    logic [NWIN-1:0] hit_w;
    logic [PW-1:0]   phys_w [NWIN];

    for (genvar g = 0; g < NWIN; g++) begin : g_win
        localparam int          SPAN  = win_span(g);
        localparam logic [31:0] BASE  = win_base(g);
        localparam logic [31:0] PBASE = win_phys(g);

        // Per-window address match and physical offset.
        always_comb begin
            hit_w[g]  = win_enabled(g, cfg) && (addr[AW-1:SPAN] == BASE[AW-1:SPAN]);
            phys_w[g] = hit_w[g] ? (PBASE[PW-1:0] | PW'(addr[SPAN-1:0])) : '0;
        end
    end

    // Merge the window results.
    always_comb begin
        hit  = |hit_w;
        phys = '0;
        for (int i = 0; i < NWIN; i++) begin
            phys = phys | phys_w[i];
        end
    end

    // Flag the cartridge ROM address space.
    always_comb begin
        cart_zone = (addr[AW-1:CART_SPAN] == '0);
    end

endmodule

// File: rtl/xram_bus_gate.sv
// Bus gating: turns a decoded hit into RAM/ROM selects and masks the strobes
// passed to the rear connector. Assumes rd_n and wr_n are never both low.
module xram_bus_gate (
    input  logic hit,
    input  logic cart_zone,
    input  logic cart,
    input  logic mreq_n,
    input  logic rfsh_n,
    input  logic rd_n,
    input  logic wr_n,
    output logic ram_sel,
    output logic ram_oe,
    output logic ram_we,
    output logic rom_sel,
    output logic rear_mreq_n,
    output logic rear_rfsh_n
);

    logic access;
    logic rom_claim;

    // Recognise a real memory transfer and a cartridge claim.
    always_comb begin
        access    = ~mreq_n & (~rd_n | ~wr_n);
        rom_claim = cart & cart_zone;
    end

    // Drive the selects and enables.
    always_comb begin
        ram_sel = hit & access;
        ram_oe  = ram_sel & ~rd_n;
        ram_we  = ram_sel & ~wr_n & rfsh_n;
        rom_sel = rom_claim & access;
    end

    // Hide claimed cycles from the rear connector.
    always_comb begin
        rear_mreq_n = mreq_n | hit | rom_claim;
        rear_rfsh_n = rfsh_n | rom_claim;
    end

endmodule

// File: rtl/xram_map_dec.sv
// Top of the memory map decoder: a registered switch configuration feeds a
// combinational window decode and bus gating. Assumes all inputs are
// synchronous to clk; reset is synchronous and active low.
module xram_map_dec
    import xram_map_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int RAM_W  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              mreq_n,
    input  logic              rfsh_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              sw_main16k,
    input  logic              sw_mirror8k,
    input  logic              sw_charbd,
    input  logic              sw_upper16k,
    input  logic              cart_present,
    output logic              ram_sel,
    output logic              ram_oe,
    output logic              ram_we,
    output logic [RAM_W-1:0]  ram_addr,
    output logic              rom_sel,
    output logic              rear_mreq_n,
    output logic              rear_rfsh_n
);

    map_cfg_t cfg_d;
    map_cfg_t cfg_q;
    logic     hit;
    logic     cart_zone;

    // Gather the raw configuration inputs.
    always_comb begin
        cfg_d.main16k  = sw_main16k;
        cfg_d.mirror8k = sw_mirror8k;
        cfg_d.charbd   = sw_charbd;
        cfg_d.upper16k = sw_upper16k;
        cfg_d.cart     = cart_present;
    end

    xram_cfg_reg cfg_i (
        .clk   (clk),
        .rst_n (rst_n),
        .cfg_d (cfg_d),
        .cfg_q (cfg_q)
    );

    xram_win_dec #(
        .AW (ADDR_W),
        .PW (RAM_W)
    ) dec_i (
        .addr      (addr),
        .cfg       (cfg_q),
        .hit       (hit),
        .phys      (ram_addr),
        .cart_zone (cart_zone)
    );

    xram_bus_gate gate_i (
        .hit         (hit),
        .cart_zone   (cart_zone),
        .cart        (cfg_q.cart),
        .mreq_n      (mreq_n),
        .rfsh_n      (rfsh_n),
        .rd_n        (rd_n),
        .wr_n        (wr_n),
        .ram_sel     (ram_sel),
        .ram_oe      (ram_oe),
        .ram_we      (ram_we),
        .rom_sel     (rom_sel),
        .rear_mreq_n (rear_mreq_n),
        .rear_rfsh_n (rear_rfsh_n)
    );

endmodule

// File: rtl/xram_map_chk.sv
// Checker for xram_map_dec: port-level properties of the selects, the
// physical address folding and the rear-connector strobes. Bound below.
module xram_map_chk #(
    parameter int AW = 16,
    parameter int PW = 15
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] addr,
    input logic          mreq_n,
    input logic          rfsh_n,
    input logic          rd_n,
    input logic          wr_n,
    input logic          ram_sel,
    input logic          ram_oe,
    input logic          ram_we,
    input logic [PW-1:0] ram_addr,
    input logic          rom_sel,
    input logic          rear_mreq_n,
    input logic          rear_rfsh_n
);

    assert_main_fold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_sel && addr[AW-1 -: 2] == 2'b01) |-> (ram_addr == {1'b0, addr[13:0]}));

    assert_chr_alias_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_sel && addr[AW-1 -: 6] == 6'b100001) |-> (ram_addr[PW-1 -: 5] == 5'b10001));

    assert_rom_ram_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(rom_sel && ram_sel));

    assert_sel_in_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_sel || rom_sel) |-> (!mreq_n && (!rd_n || !wr_n)));

    assert_oe_on_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ram_oe |-> (!rd_n && ram_sel));

    assert_no_refresh_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rfsh_n |-> !ram_we);

    assert_rear_hidden_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_sel || rom_sel) |-> rear_mreq_n);

    assert_rom_rfsh_hidden_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rom_sel |-> rear_rfsh_n);

endmodule

bind xram_map_dec xram_map_chk #(
    .AW (ADDR_W),
    .PW (RAM_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr        (addr),
    .mreq_n      (mreq_n),
    .rfsh_n      (rfsh_n),
    .rd_n        (rd_n),
    .wr_n        (wr_n),
    .ram_sel     (ram_sel),
    .ram_oe      (ram_oe),
    .ram_we      (ram_we),
    .ram_addr    (ram_addr),
    .rom_sel     (rom_sel),
    .rear_mreq_n (rear_mreq_n),
    .rear_rfsh_n (rear_rfsh_n)
);

// File: tb/xram_map_dec_tb_top.sv
// Bench: sweeps all switch/cartridge combinations over every address page and
// five bus cycle kinds, comparing against an arithmetic model of the map.
`timescale 1ns/1ps
module xram_map_dec_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic        mreq_n = 1'b1, rfsh_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic        sw_main16k = 1'b0, sw_mirror8k = 1'b0, sw_charbd = 1'b0;
    logic        sw_upper16k = 1'b0, cart_present = 1'b0;
    logic        ram_sel, ram_oe, ram_we, rom_sel, rear_mreq_n, rear_rfsh_n;
    logic [14:0] ram_addr;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    xram_map_dec dut_i (
        .clk (clk), .rst_n (rst_n), .addr (addr),
        .mreq_n (mreq_n), .rfsh_n (rfsh_n), .rd_n (rd_n), .wr_n (wr_n),
        .sw_main16k (sw_main16k), .sw_mirror8k (sw_mirror8k),
        .sw_charbd (sw_charbd), .sw_upper16k (sw_upper16k),
        .cart_present (cart_present),
        .ram_sel (ram_sel), .ram_oe (ram_oe), .ram_we (ram_we),
        .ram_addr (ram_addr), .rom_sel (rom_sel),
        .rear_mreq_n (rear_mreq_n), .rear_rfsh_n (rear_rfsh_n)
    );

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s addr=%h got=%h expected=%h", tag, addr, got, exp);
        end
    endtask

    // Cycle kinds: 0 idle, 1 read, 2 write, 3 refresh, 4 refresh with wr_n low.
    task automatic drive_cycle(input int kind);
        mreq_n = (kind == 0);
        rd_n   = (kind != 1);
        wr_n   = !(kind == 2 || kind == 4);
        rfsh_n = !(kind == 3 || kind == 4);
    endtask

    // Arithmetic model of the map; returns region tag, hit and physical address.
    task automatic model(input int a, input bit m16, input bit m8, input bit chr,
                         input bit up, input bit cart,
                         output bit hit, output int phys, output string tag);
        hit = 1'b0; phys = 0; tag = "R7";
        if (m16 && a >= 'h4000 && a < 'h8000) begin
            hit = 1'b1; phys = a - 'h4000; tag = "R2";
        end else if (m8 && !cart && ((a >= 'h2000 && a < 'h4000) || (a >= 'hA000 && a < 'hC000))) begin
            hit = 1'b1; phys = 'h6000 + a % 'h2000; tag = "R3";
        end else if (up && a >= 'hC000) begin
            hit = 1'b1; phys = 'h4000 + (a - 'hC000); tag = "R4";
        end else if (chr && ((a >= 'h8400 && a < 'h8800) || (a >= 'hC400 && a < 'hC800))) begin
            hit = 1'b1; phys = 'h4400 + a % 'h400; tag = "R5";
        end else if (cart && a < 'h4000) begin
            tag = "R6";
        end
    endtask

    initial begin
        // R1: reset with everything requested on.
        {sw_main16k, sw_mirror8k, sw_charbd, sw_upper16k, cart_present} = 5'b11111;
        addr = 16'h4000; drive_cycle(1);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 ram_sel", int'(ram_sel), 0);
        check("R1 rear_mreq_n", int'(rear_mreq_n), 0);
        addr = 16'h1000; #1;
        check("R1 rom_sel", int'(rom_sel), 0);
        {sw_main16k, sw_mirror8k, sw_charbd, sw_upper16k, cart_present} = 5'b00000;
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);

        // R11: a switch change waits for the next edge.
        addr = 16'h4000; drive_cycle(1);
        sw_main16k = 1'b1; #2;
        check("R11 before edge", int'(ram_sel), 0);
        @(posedge clk); #2;
        check("R11 after edge", int'(ram_sel), 1);
        @(negedge clk);
        sw_main16k = 1'b0; #2;
        check("R11 still on", int'(ram_sel), 1);
        @(posedge clk); #2;
        check("R11 off after edge", int'(ram_sel), 0);

        // Exhaustive configuration sweep.
        for (int c = 0; c < 32; c++) begin
            @(negedge clk);
            {sw_main16k, sw_mirror8k, sw_charbd, sw_upper16k, cart_present} = c[4:0];
            @(posedge clk); #2;
            for (int p = 0; p < 256; p++) begin
                for (int k = 0; k < 5; k++) begin
                    bit    hit;
                    int    phys;
                    string tag;
                    int    a;
                    bit    cartz;
                    bit    acc;
                    a = p * 256 + ((p * 37 + c * 11 + 5) % 256);
                    addr = a[15:0];
                    drive_cycle(k);
                    #1;
                    model(a, c[4], c[3], c[2], c[1], c[0], hit, phys, tag);
                    cartz = c[0] && a < 'h4000;
                    acc   = (k == 1 || k == 2 || k == 4);
                    check({tag, " ram_sel"}, int'(ram_sel), int'(hit && acc));
                    if (hit && acc)
                        check({tag, " ram_addr"}, int'(ram_addr), phys);
                    check("R7 ram_oe", int'(ram_oe), int'(hit && k == 1));
                    check("R8 ram_we", int'(ram_we), int'(hit && k == 2));
                    check("R6 rom_sel", int'(rom_sel), int'(cartz && acc));
                    check("R9 rear_mreq_n", int'(rear_mreq_n), int'(mreq_n || hit || cartz));
                    check("R10 rear_rfsh_n", int'(rear_rfsh_n), int'(rfsh_n || cartz));
                    #1;
                end
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(20 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired got=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule